// File: doc/BRIEF.md
# Prioritized Interrupt Request Selector

This block gathers interrupt requests from twelve expansion card slots and from five system board sources and reduces them to a single priority level and vector for the processor. Each card slot holds a pending flag that a one-cycle raise pulse sets. The slot also carries a programmed level and vector. The lowest-numbered pending slot always wins. Any pending card beats every board source. When no card is pending, the board sources are tried in a fixed order that does not follow their numeric levels.

The winning pair is captured into a register on a sample strobe, so it stays steady while the processor decides. The block raises take-interrupt when the captured level is strictly above the current processor priority. An acknowledge pulse while take-interrupt is high does two things. It clears every pending slot whose level and vector both equal the captured pair, and it zeroes the captured pair. The block also gives the handler-pointer address for the delivered vector. A non-maskable request forces the delivered vector to zero.

Top module: `irq_arbiter`

## Requirements
- R1: After reset all slot pending flags are 0, the captured level and vector are 0, and takeIrq is low.
- R2: A pulse on slotRaise[i] makes slotPending[i] read 1 from the next clock edge on. The flag stays set until an acknowledge clears it.
- R3: When any slot is pending, the lowest-indexed pending slot supplies both level and vector. No board source is considered, whatever its level.
- R4: With no slot pending, the board sources are tried in this order:
  - soft request A gives level 8;
  - soft request B gives level 9;
  - the disk controller line OR the disk status bit gives level 11;
  - the serial line OR the DMA line gives level 13;
  - the timer gives level 15.
  The vector equals the level. With nothing pending the selection is level 0, vector 0.
- R5: irqLevel and the captured vector load the current selection on the edge where sampleStb is high, and hold their value on every other edge except an honoured acknowledge.
- R6: takeIrq is high exactly when curPriority is strictly less than irqLevel, compared as unsigned numbers.
- R7: An acknowledge while takeIrq is high clears every pending slot whose programmed level and vector both equal the captured pair, and leaves other slots pending. On the same edge it zeroes the captured level and vector. If sampleStb is high in that cycle, the sample is ignored.
- R8: An acknowledge while takeIrq is low changes no pending flag and no captured value.
- R9: While nmiReq is high, irqVector reads 0. irqLevel is unaffected.
- R10: handlerAddr equals 0x8C plus four times irqVector.
- R11: If a slot's raise pulse comes on the same edge that an acknowledge would clear that slot, the slot stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotRaise | input | 12 | Per-slot request pulse; sets that slot's pending flag |
| slotLevels | input | 48 | Programmed level of slot i in bits [4i+3:4i] |
| slotVectors | input | 96 | Programmed vector of slot i in bits [8i+7:8i] |
| softReqA | input | 1 | Board soft request A (level 8) |
| softReqB | input | 1 | Board soft request B (level 9) |
| diskCtlReq | input | 1 | Disk controller request line (level 11) |
| diskStatusReq | input | 1 | Latched disk status bit (level 11) |
| serialReq | input | 1 | Serial request line (level 13) |
| dmaReq | input | 1 | DMA request line (level 13) |
| timerReq | input | 1 | Timer request (level 15) |
| nmiReq | input | 1 | Non-maskable request; forces the delivered vector to 0 |
| sampleStb | input | 1 | Captures the current selection |
| curPriority | input | 4 | Current processor priority |
| ack | input | 1 | Acknowledge pulse from the processor |
| slotPending | output | 12 | Pending flag of each slot |
| irqLevel | output | 4 | Captured level |
| irqVector | output | 8 | Delivered vector |
| takeIrq | output | 1 | Captured level is above curPriority |
| handlerAddr | output | 16 | Word address of the handler pointer |

## Verification
The bench aims at the cases where priority order and numeric level disagree:
- A level-15 timer must lose to soft request A at level 8.
- A low-level card must beat every board source.
- A lower slot index must win over a higher one with a larger level.
A selector that sorted by level would deliver the wrong pair in each of these cases.

Acknowledge is tested with two slots that share one level and vector pair, and with a third slot that shares only the level. A design that cleared only the winning slot would leave a stale request pending. A design that matched on level alone would silently drop a live request.

Further checks cover:
- an acknowledge while priority masks the request, which must be ignored;
- acknowledge and sample in the same cycle;
- a raise landing on the clearing edge;
- the strict priority comparison at equality;
- the non-maskable vector override and the handler address that follows from it.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // load selection into the latch
    logic clear;     // honoured acknowledge: clear matches, zero latch
  } irqStrobes_t;

  // fixed board source levels (vector equals level)
  localparam int LVL_SOFT_A = 8;
  localparam int LVL_SOFT_B = 9;
  localparam int LVL_DISK   = 11;
  localparam int LVL_SERDMA = 13;
  localparam int LVL_TIMER  = 15;

endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_sel_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             sampleStb,
  input  logic             ack,
  input  logic [LVL_W-1:0] curPriority,
  input  logic [LVL_W-1:0] latchLevel,
  output logic             takeIrq,
  output irqStrobes_t      strobes
);

  always_comb begin
    takeIrq         = (curPriority < latchLevel);
    strobes.clear   = ack && takeIrq;
    // an honoured acknowledge wins over a sample in the same cycle
    strobes.capture = sampleStb && !strobes.clear;
  end

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_sel_pkg::*;
#(
  parameter int NSLOT = 12,
  parameter int LVL_W = 4,
  parameter int VEC_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NSLOT-1:0]       slotRaise,
  input  logic [NSLOT*LVL_W-1:0] slotLevels,
  input  logic [NSLOT*VEC_W-1:0] slotVectors,
  input  logic                   softReqA,
  input  logic                   softReqB,
  input  logic                   diskCtlReq,
  input  logic                   diskStatusReq,
  input  logic                   serialReq,
  input  logic                   dmaReq,
  input  logic                   timerReq,
  input  irqStrobes_t            strobes,
  output logic [NSLOT-1:0]       slotPending,
  output logic [LVL_W-1:0]       latchLevel,
  output logic [VEC_W-1:0]       latchVec
);

  logic             cardHit;
  logic [LVL_W-1:0] cardLvl, boardLvl, selLvl;
  logic [VEC_W-1:0] cardVec, selVec;
  logic [NSLOT-1:0] clearMask;

  // card scan: walk downward so the lowest pending index is written last
  always_comb begin
    cardHit = 1'b0;
    cardLvl = '0;
    cardVec = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (slotPending[i]) begin
        cardHit = 1'b1;
        cardLvl = slotLevels[i*LVL_W +: LVL_W];
        cardVec = slotVectors[i*VEC_W +: VEC_W];
      end
    end
  end

  // board sources in fixed order, independent of numeric level
  always_comb begin
    if (softReqA)                        boardLvl = LVL_W'(LVL_SOFT_A);
    else if (softReqB)                   boardLvl = LVL_W'(LVL_SOFT_B);
    else if (diskCtlReq || diskStatusReq) boardLvl = LVL_W'(LVL_DISK);
    else if (serialReq || dmaReq)        boardLvl = LVL_W'(LVL_SERDMA);
    else if (timerReq)                   boardLvl = LVL_W'(LVL_TIMER);
    else                                 boardLvl = '0;
    selLvl = cardHit ? cardLvl : boardLvl;
    selVec = cardHit ? cardVec : VEC_W'(boardLvl);
  end

  // slots matching the captured pair on an honoured acknowledge
  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      clearMask[i] = strobes.clear
                  && (slotLevels[i*LVL_W +: LVL_W] == latchLevel)
                  && (slotVectors[i*VEC_W +: VEC_W] == latchVec);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotPending <= '0;
    end else begin
      // a raise on the clearing edge keeps the slot pending
      slotPending <= slotRaise | (slotPending & ~clearMask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchLevel <= '0;
      latchVec   <= '0;
    end else if (strobes.clear) begin
      latchLevel <= '0;
      latchVec   <= '0;
    end else if (strobes.capture) begin
      latchLevel <= selLvl;
      latchVec   <= selVec;
    end
  end

  // R5: latch only moves on a strobe from control
  a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.capture && !strobes.clear) |=> ($stable(latchLevel) && $stable(latchVec)));

  for (genvar g = 0; g < NSLOT; g++) begin : gSlotChk
    // R2: a raise pulse is always visible on the next edge
    a_r2_raise_sets: assert property (@(posedge clk) disable iff (!rstN)
      slotRaise[g] |=> slotPending[g]);
    // R7: a flag drops only on an honoured acknowledge
    a_r7_drop_needs_ack: assert property (@(posedge clk) disable iff (!rstN)
      $fell(slotPending[g]) |-> $past(strobes.clear));
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_sel_pkg::*;
#(
  parameter int NSLOT    = 12,
  parameter int LVL_W    = 4,
  parameter int VEC_W    = 8,
  parameter int ADDR_W   = 16,
  parameter int VEC_BASE = 'h8C
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NSLOT-1:0]       slotRaise,
  input  logic [NSLOT*LVL_W-1:0] slotLevels,
  input  logic [NSLOT*VEC_W-1:0] slotVectors,
  input  logic                   softReqA,
  input  logic                   softReqB,
  input  logic                   diskCtlReq,
  input  logic                   diskStatusReq,
  input  logic                   serialReq,
  input  logic                   dmaReq,
  input  logic                   timerReq,
  input  logic                   nmiReq,
  input  logic                   sampleStb,
  input  logic [LVL_W-1:0]       curPriority,
  input  logic                   ack,
  output logic [NSLOT-1:0]       slotPending,
  output logic [LVL_W-1:0]       irqLevel,
  output logic [VEC_W-1:0]       irqVector,
  output logic                   takeIrq,
  output logic [ADDR_W-1:0]      handlerAddr
);

  localparam int PTR_SHIFT = 2;  // pointers are four bytes apart

  irqStrobes_t      strobes;
  logic [VEC_W-1:0] latchVec;

  irq_ctrl #(.LVL_W(LVL_W)) uCtrl (
    .sampleStb  (sampleStb),
    .ack        (ack),
    .curPriority(curPriority),
    .latchLevel (irqLevel),
    .takeIrq    (takeIrq),
    .strobes    (strobes)
  );

  irq_datapath #(.NSLOT(NSLOT), .LVL_W(LVL_W), .VEC_W(VEC_W)) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .slotRaise    (slotRaise),
    .slotLevels   (slotLevels),
    .slotVectors  (slotVectors),
    .softReqA     (softReqA),
    .softReqB     (softReqB),
    .diskCtlReq   (diskCtlReq),
    .diskStatusReq(diskStatusReq),
    .serialReq    (serialReq),
    .dmaReq       (dmaReq),
    .timerReq     (timerReq),
    .strobes      (strobes),
    .slotPending  (slotPending),
    .latchLevel   (irqLevel),
    .latchVec     (latchVec)
  );

  assign irqVector   = nmiReq ? '0 : latchVec;
  assign handlerAddr = ADDR_W'(VEC_BASE) + (ADDR_W'(irqVector) << PTR_SHIFT);

  // R6: a taken interrupt implies a nonzero captured level
  a_r6_take_needs_level: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (irqLevel != '0));

  // R7: honoured acknowledge zeroes the captured level
  a_r7_latch_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (ack && takeIrq) |=> (irqLevel == '0));

  // R8: masked acknowledge with no other activity changes nothing
  a_r8_ack_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !takeIrq && !sampleStb && (slotRaise == '0))
      |=> ($stable(irqLevel) && $stable(slotPending)));

endmodule

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;

  localparam int NSLOT = 12;

  logic clk = 1'b0;
  logic rstN;
  logic [NSLOT-1:0]   slotRaise;
  logic [NSLOT*4-1:0] slotLevels;
  logic [NSLOT*8-1:0] slotVectors;
  logic softReqA, softReqB, diskCtlReq, diskStatusReq, serialReq, dmaReq, timerReq, nmiReq;
  logic sampleStb, ack;
  logic [3:0] curPriority;
  logic [NSLOT-1:0] slotPending;
  logic [3:0]  irqLevel;
  logic [7:0]  irqVector;
  logic        takeIrq;
  logic [15:0] handlerAddr;

  logic [3:0] lvlArr [NSLOT];
  logic [7:0] vecArr [NSLOT];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  bit refFlag [NSLOT];
  int refLvl, refVec;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      slotLevels[i*4 +: 4]  = lvlArr[i];
      slotVectors[i*8 +: 8] = vecArr[i];
    end
  end

  irq_arbiter uut (
    .clk(clk), .rstN(rstN), .slotRaise(slotRaise), .slotLevels(slotLevels),
    .slotVectors(slotVectors), .softReqA(softReqA), .softReqB(softReqB),
    .diskCtlReq(diskCtlReq), .diskStatusReq(diskStatusReq), .serialReq(serialReq),
    .dmaReq(dmaReq), .timerReq(timerReq), .nmiReq(nmiReq), .sampleStb(sampleStb),
    .curPriority(curPriority), .ack(ack), .slotPending(slotPending),
    .irqLevel(irqLevel), .irqVector(irqVector), .takeIrq(takeIrq),
    .handlerAddr(handlerAddr)
  );

  task automatic expectEq(string tag, int actual, int expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  // behavioural model of one clock edge, using the inputs held at the edge
  task automatic modelEdge();
    int sLvl, sVec;
    bit found, take;
    if (!rstN) begin
      for (int i = 0; i < NSLOT; i++) refFlag[i] = 0;
      refLvl = 0; refVec = 0;
      return;
    end
    found = 0; sLvl = 0; sVec = 0;
    for (int i = 0; i < NSLOT; i++)
      if (!found && refFlag[i]) begin found = 1; sLvl = lvlArr[i]; sVec = vecArr[i]; end
    if (!found) begin
      if (softReqA) sLvl = 8;
      else if (softReqB) sLvl = 9;
      else if (diskCtlReq || diskStatusReq) sLvl = 11;
      else if (serialReq || dmaReq) sLvl = 13;
      else if (timerReq) sLvl = 15;
      else sLvl = 0;
      sVec = sLvl;
    end
    take = (int'(curPriority) < refLvl);
    if (ack && take) begin
      for (int i = 0; i < NSLOT; i++)
        if (refFlag[i] && lvlArr[i] == refLvl && vecArr[i] == refVec) refFlag[i] = 0;
      refLvl = 0; refVec = 0;
    end else if (sampleStb) begin
      refLvl = sLvl; refVec = sVec;
    end
    for (int i = 0; i < NSLOT; i++) if (slotRaise[i]) refFlag[i] = 1;
  endtask

  task automatic compareAll();
    int expVec;
    for (int i = 0; i < NSLOT; i++) expectEq("R2 pending", slotPending[i], refFlag[i]);
    expectEq("R5 irqLevel", irqLevel, refLvl);
    expVec = nmiReq ? 0 : refVec;
    expectEq("R9 irqVector", irqVector, expVec);
    expectEq("R6 takeIrq", takeIrq, int'(curPriority) < refLvl);
    expectEq("R10 handlerAddr", handlerAddr, 'h8C + 4 * expVec);
  endtask

  // one clock: inputs already driven; model the edge, compare at negedge, clear pulses
  task automatic tick();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
    slotRaise = '0; sampleStb = 0; ack = 0;
  endtask

  task automatic clearBoard();
    softReqA = 0; softReqB = 0; diskCtlReq = 0; diskStatusReq = 0;
    serialReq = 0; dmaReq = 0; timerReq = 0;
  endtask

  task automatic sampleNow();
    sampleStb = 1; tick();
  endtask

  initial begin
    rstN = 0; slotRaise = '0; sampleStb = 0; ack = 0; nmiReq = 0; curPriority = 4'd15;
    clearBoard();
    for (int i = 0; i < NSLOT; i++) begin lvlArr[i] = 4'd1 + 4'(i % 7); vecArr[i] = 8'h40 + 8'(i); end
    lvlArr[3] = 4'd10; vecArr[3] = 8'h55;
    lvlArr[7] = 4'd10; vecArr[7] = 8'h55;
    lvlArr[9] = 4'd10; vecArr[9] = 8'h56;   // same level, other vector
    lvlArr[5] = 4'd2;  vecArr[5] = 8'h60;
    @(negedge clk);
    tick(); tick();
    rstN = 1;
    tick();
    // R1 reset state
    expectEq("R1 level after reset", irqLevel, 0);
    expectEq("R1 take after reset", takeIrq, 0);
    expectEq("R1 pending after reset", slotPending, 0);

    // R4 board order, against numeric level
    timerReq = 1; sampleNow();
    expectEq("R4 timer level", irqLevel, 15);
    expectEq("R4 timer vector", irqVector, 15);
    dmaReq = 1; sampleNow();
    expectEq("R4 dma level", irqLevel, 13);
    dmaReq = 0; serialReq = 1; sampleNow();
    expectEq("R4 serial level", irqLevel, 13);
    diskStatusReq = 1; sampleNow();
    expectEq("R4 disk status level", irqLevel, 11);
    diskStatusReq = 0; diskCtlReq = 1; sampleNow();
    expectEq("R4 disk ctl level", irqLevel, 11);
    softReqB = 1; sampleNow();
    expectEq("R4 softB level", irqLevel, 9);
    softReqA = 1; sampleNow();
    expectEq("R4 softA beats timer", irqLevel, 8);
    expectEq("R4 softA vector", irqVector, 8);
    tick(); tick();
    expectEq("R5 held without sample", irqLevel, 8);
    clearBoard(); sampleNow();
    expectEq("R4 nothing pending", irqLevel, 0);

    // R3 cards beat board sources; lowest index wins
    softReqA = 1; timerReq = 1;
    slotRaise[7] = 1; tick();
    sampleNow();
    expectEq("R3 card beats board level", irqLevel, 10);
    expectEq("R3 card vector", irqVector, 8'h55);
    slotRaise[5] = 1; slotRaise[9] = 1; tick();
    sampleNow();
    expectEq("R3 lowest index wins", irqLevel, 2);
    expectEq("R3 lowest index vector", irqVector, 8'h60);
    expectEq("R10 address of vector 60", handlerAddr, 'h20C);

    // R6 strict comparison
    curPriority = 4'd2; tick();
    expectEq("R6 equal priority not taken", takeIrq, 0);
    curPriority = 4'd1; tick();
    expectEq("R6 lower priority taken", takeIrq, 1);

    // R8 acknowledge while masked
    curPriority = 4'd2; ack = 1; tick();
    expectEq("R8 masked ack keeps level", irqLevel, 2);
    expectEq("R8 masked ack keeps slot5", slotPending[5], 1);

    // R7 acknowledge clears slot 5 only, sample in same cycle ignored
    curPriority = 4'd0; ack = 1; sampleStb = 1; tick();
    expectEq("R7 slot5 cleared", slotPending[5], 0);
    expectEq("R7 slot7 kept", slotPending[7], 1);
    expectEq("R7 latch zeroed over sample", irqLevel, 0);

    // R7 multi-match clear, level-only match kept
    slotRaise[3] = 1; tick();
    sampleNow();
    expectEq("R3 slot3 wins", irqVector, 8'h55);
    ack = 1; tick();
    expectEq("R7 slot3 cleared", slotPending[3], 0);
    expectEq("R7 slot7 cleared as twin", slotPending[7], 0);
    expectEq("R7 slot9 other vector kept", slotPending[9], 1);

    // R11 raise on the clearing edge
    sampleNow();
    expectEq("R3 slot9 now wins", irqVector, 8'h56);
    ack = 1; slotRaise[9] = 1; tick();
    expectEq("R11 raise survives clear", slotPending[9], 1);
    expectEq("R7 latch zero after clear", irqLevel, 0);

    // R9 non-maskable override
    sampleNow();
    nmiReq = 1; tick();
    expectEq("R9 nmi vector zero", irqVector, 0);
    expectEq("R9 nmi level kept", irqLevel, 10);
    expectEq("R10 nmi address", handlerAddr, 'h8C);
    nmiReq = 0; tick();
    expectEq("R9 vector back", irqVector, 8'h56);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule